// File: doc/BRIEF.md
# Countdown Timer with Load and Reload

This block is a register-controlled down-counter that can be used three ways. Software can poll it by taking snapshots of the running count. It can run as a single timed interval that expires once, or as a repeating period. While the run bit is clear, the count register keeps following a start-value register. Setting the run bit therefore starts the countdown from that start value. When the count reaches zero it takes a second, separate restart value on the following clock. A restart value of zero leaves the timer parked at zero, which gives the single-interval behaviour.

Software cannot read the live count directly. Any write to a trigger register copies the count into a readable snapshot register. The moment the count drops from nonzero to zero is the expiry event. This event sets a sticky pending flag, which software clears by writing 1 to it. The interrupt output is the pending flag gated by a mask bit. A status register shows the raw level of the event source, which is count not equal to zero.

Accesses use a simple single-cycle bus. A write is captured on the rising clock edge while `bus_we` is high. Read data is combinational from `bus_addr`. Only the eight word-aligned byte offsets listed in R1 decode. Any other address reads zero and writes nothing.

Top module: `cdtimer`

## Requirements
- R1: Byte offsets are 0x00 start value, 0x04 restart value, 0x08 run bit (bit 0), 0x0C snapshot trigger (write only, reads 0), 0x10 snapshot value, 0x14 event status (bit 0), 0x18 event pending (bit 0), 0x1C event mask (bit 0). The start, restart, run and mask registers read back what was written. After reset every register reads 0 and `irq` is 0.
- R2: While the run bit is 0, the count takes the start value on every clock. A new start value is visible in the count one clock after it is written.
- R3: While the run bit is 1 and the count is nonzero, the count decreases by exactly one on each clock.
- R4: While the run bit is 1 and the count is zero, the count takes the restart value on the next clock. With a restart value of 0 the count stays at 0 after it expires (single interval).
- R5: A write of any data to offset 0x0C stores the count held before that clock edge into the snapshot value. Without such a write the snapshot value does not change.
- R6: Event status bit 0 reads 1 exactly when the count is nonzero. Writes to offset 0x14 have no effect.
- R7: The pending bit becomes 1 on the same clock edge at which the count goes from nonzero to zero. Writing a 1 in bit 0 of offset 0x18 clears it. Writing a 0 in that bit leaves it unchanged.
- R8: If the count goes to zero on the same edge as a clearing write to the pending bit, the pending bit ends up 1.
- R9: `irq` is 1 exactly when the pending bit and the event mask bit are both 1.
- R10: With start value 0 and restart value P > 0, the timer runs periodically. After the run bit is set, the count steps P, P-1, ..., 0 and repeats. Zero is reached every P+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (5) | Byte offset of the register accessed |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt: pending AND mask |

## Verification
The bench sweeps small start values, restart values and waiting times. For each combination it snapshots the count at a known clock and compares the result with a closed-form prediction of the countdown.

A design that reloads one clock too early or too late would shift every later value. A design that loads the restart value instead of the start value on enable would fail the first cycles of each case. Sampling the snapshot one cycle late would show up in the same cases.

The bench also forces an expiry onto the very edge that clears the pending bit. A design that lets the clear win would lose that interrupt. Finally, it writes the status register and writes zero to the pending bit, which exposes designs that treat those writes as stores or as clears.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // byte offsets of the register window
  localparam logic [7:0] OFS_START   = 8'h00;
  localparam logic [7:0] OFS_RESTART = 8'h04;
  localparam logic [7:0] OFS_RUN     = 8'h08;
  localparam logic [7:0] OFS_SNAP    = 8'h0C;
  localparam logic [7:0] OFS_VALUE   = 8'h10;
  localparam logic [7:0] OFS_EVSTAT  = 8'h14;
  localparam logic [7:0] OFS_EVPEND  = 8'h18;
  localparam logic [7:0] OFS_EVMASK  = 8'h1C;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_START,
    SEL_RESTART,
    SEL_RUN,
    SEL_SNAP,
    SEL_VALUE,
    SEL_EVSTAT,
    SEL_EVPEND,
    SEL_EVMASK
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [7:0] ofs);
    case (ofs)
      OFS_START:   return SEL_START;
      OFS_RESTART: return SEL_RESTART;
      OFS_RUN:     return SEL_RUN;
      OFS_SNAP:    return SEL_SNAP;
      OFS_VALUE:   return SEL_VALUE;
      OFS_EVSTAT:  return SEL_EVSTAT;
      OFS_EVPEND:  return SEL_EVPEND;
      OFS_EVMASK:  return SEL_EVMASK;
      default:     return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cdt_regfile.sv
module cdt_regfile
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_nz,
  input  logic              pend,
  input  logic [CNT_W-1:0]  value,
  output logic [CNT_W-1:0]  start_q,
  output logic [CNT_W-1:0]  restart_q,
  output logic              run_q,
  output logic              evmask_q,
  output logic              snap_wr,
  output logic              pend_clr
);

  reg_sel_e sel;

  always_comb sel = decode_sel(8'(bus_addr));

  // write strobes that other pieces of the block act on
  always_comb begin
    snap_wr  = bus_we && (sel == SEL_SNAP);
    pend_clr = bus_we && (sel == SEL_EVPEND) && bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      restart_q <= '0;
      run_q     <= 1'b0;
      evmask_q  <= 1'b0;
    end else if (bus_we) begin
      case (sel)
        SEL_START:   start_q   <= bus_wdata[CNT_W-1:0];
        SEL_RESTART: restart_q <= bus_wdata[CNT_W-1:0];
        SEL_RUN:     run_q     <= bus_wdata[0];
        SEL_EVMASK:  evmask_q  <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_START:   bus_rdata = DATA_W'(start_q);
      SEL_RESTART: bus_rdata = DATA_W'(restart_q);
      SEL_RUN:     bus_rdata = DATA_W'(run_q);
      SEL_VALUE:   bus_rdata = DATA_W'(value);
      SEL_EVSTAT:  bus_rdata = DATA_W'(cnt_nz);
      SEL_EVPEND:  bus_rdata = DATA_W'(pend);
      SEL_EVMASK:  bus_rdata = DATA_W'(evmask_q);
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] restart_val,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_d
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // next count: follow start while stopped, step down, or restart at zero
  function automatic logic [CNT_W-1:0] next_count(
    input logic             go,
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] st,
    input logic [CNT_W-1:0] rs
  );
    if (!go)        return st;
    if (cur != '0)  return cur - ONE;
    return rs;
  endfunction

  always_comb count_d = next_count(run, count_q, start_val, restart_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

endmodule

// File: rtl/cdt_snapshot.sv
module cdt_snapshot #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_wr,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] value_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value_q <= '0;
    else if (snap_wr) value_q <= count;
  end

endmodule

// File: rtl/cdt_events.sv
module cdt_events #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_q,
  input  logic [CNT_W-1:0] count_d,
  input  logic             pend_clr,
  input  logic             evmask,
  output logic             src_lvl,
  output logic             zero_fall,
  output logic             pend_q,
  output logic             irq
);

  // falling edge of the source level happens as the count enters zero
  function automatic logic enters_zero(
    input logic [CNT_W-1:0] now,
    input logic [CNT_W-1:0] nxt
  );
    return (now != '0) && (nxt == '0);
  endfunction

  always_comb begin
    src_lvl   = (count_q != '0);
    zero_fall = enters_zero(count_q, count_d);
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (zero_fall) pend_q <= 1'b1;
    else if (pend_clr)  pend_q <= 1'b0;
  end

  always_comb irq = pend_q & evmask;

endmodule

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] restart_q;
  logic             run_q;
  logic             evmask_q;
  logic             snap_wr;
  logic             pend_clr;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] value_q;
  logic             src_lvl;
  logic             zero_fall;
  logic             pend_q;

  cdt_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_nz    (src_lvl),
    .pend      (pend_q),
    .value     (value_q),
    .start_q   (start_q),
    .restart_q (restart_q),
    .run_q     (run_q),
    .evmask_q  (evmask_q),
    .snap_wr   (snap_wr),
    .pend_clr  (pend_clr)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_q),
    .start_val   (start_q),
    .restart_val (restart_q),
    .count_q     (count_q),
    .count_d     (count_d)
  );

  cdt_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap_wr (snap_wr),
    .count   (count_q),
    .value_q (value_q)
  );

  cdt_events #(.CNT_W(CNT_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_q   (count_q),
    .count_d   (count_d),
    .pend_clr  (pend_clr),
    .evmask    (evmask_q),
    .src_lvl   (src_lvl),
    .zero_fall (zero_fall),
    .pend_q    (pend_q),
    .irq       (irq)
  );

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] start_val,
  input logic [CNT_W-1:0] restart_val,
  input logic             snap_wr,
  input logic [CNT_W-1:0] value,
  input logic             zero_fall,
  input logic             pend_clr,
  input logic             pend,
  input logic             evmask,
  input logic             irq
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == $past(start_val));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count != '0) |=> count == $past(count) - CNT_W'(1));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count == '0) |=> count == $past(restart_val));

  p_snap_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |=> value == $past(count));

  p_snap_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_wr |=> $stable(value));

  p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fall |=> pend);

  p_pend_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !zero_fall) |=> !pend);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && zero_fall) |=> pend);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evmask |-> !irq);

  p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

endmodule

bind cdtimer cdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run_q),
  .count       (count_q),
  .start_val   (start_q),
  .restart_val (restart_q),
  .snap_wr     (snap_wr),
  .value       (value_q),
  .zero_fall   (zero_fall),
  .pend_clr    (pend_clr),
  .pend        (pend_q),
  .evmask      (evmask_q),
  .irq         (irq)
);

// File: tb/cdtimer_tb.sv
`timescale 1ns/1ps
module cdtimer_tb;

  localparam logic [4:0] A_START = 5'h00, A_RESTART = 5'h04, A_RUN = 5'h08,
                         A_SNAP = 5'h0C, A_VALUE = 5'h10, A_STAT = 5'h14,
                         A_PEND = 5'h18, A_MASK = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cdtimer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // each write consumes exactly one rising edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // count after k edges since the enabling edge
  function automatic int exp_count(input int l, input int p, input int k);
    if (k <= l) return l - k;
    if (p == 0) return 0;
    return p - ((k - l - 1) % (p + 1));
  endfunction

  function automatic bit exp_pend(input int l, input int p, input int n);
    for (int k = 1; k <= n; k++)
      if (exp_count(l, p, k - 1) != 0 && exp_count(l, p, k) == 0) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), r);
      chk("R1 reset read", r, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R1 read back
    wr(A_START, 32'h1234_5678);   rd(A_START, r);   chk("R1 start", r, 32'h1234_5678);
    wr(A_RESTART, 32'hCAFE_F00D); rd(A_RESTART, r); chk("R1 restart", r, 32'hCAFE_F00D);
    wr(A_MASK, 32'h1);            rd(A_MASK, r);    chk("R1 mask", r, 32'h1);
    wr(A_RUN, 32'h1);             rd(A_RUN, r);     chk("R1 run", r, 32'h1);
    rd(A_SNAP, r);                                  chk("R1 trigger reads 0", r, 32'h0);
    wr(A_RUN, 32'h0);

    // R2 count follows start value while stopped
    wr(A_START, 32'd77); idle(1); wr(A_SNAP, 0);
    rd(A_VALUE, r); chk("R2 follow start", r, 32'd77);
    wr(A_START, 32'd5); idle(1); wr(A_SNAP, 0);
    rd(A_VALUE, r); chk("R2 follow new start", r, 32'd5);

    // R5 value held without trigger
    wr(A_START, 32'd9); idle(6);
    rd(A_VALUE, r); chk("R5 value unchanged", r, 32'd5);

    // R6 status level and write immunity
    rd(A_STAT, r); chk("R6 status nonzero", r, 32'h1);
    wr(A_STAT, 32'h0); rd(A_STAT, r); chk("R6 write 0 ignored", r, 32'h1);
    wr(A_START, 32'd0); idle(1);
    rd(A_STAT, r); chk("R6 status zero", r, 32'h0);
    wr(A_STAT, 32'h1); rd(A_STAT, r); chk("R6 write 1 ignored", r, 32'h0);

    // R7 pending was set by 9 -> 0; write 0 keeps it, write 1 clears it
    rd(A_PEND, r); chk("R7 set by fall", r, 32'h1);
    wr(A_PEND, 32'h0); rd(A_PEND, r); chk("R7 write 0 keeps", r, 32'h1);

    // R9 masking
    wr(A_MASK, 32'h0); chk("R9 masked irq", {31'h0, irq}, 32'h0);
    wr(A_MASK, 32'h1); chk("R9 unmasked irq", {31'h0, irq}, 32'h1);
    wr(A_PEND, 32'h1); rd(A_PEND, r); chk("R7 write 1 clears", r, 32'h0);
    chk("R9 irq after clear", {31'h0, irq}, 32'h0);

    // R8 expiry on the same edge as a clear
    wr(A_START, 32'd3); wr(A_RESTART, 32'd0); idle(1); wr(A_PEND, 32'h1);
    wr(A_RUN, 32'h1); idle(2); wr(A_PEND, 32'h1);
    rd(A_PEND, r); chk("R8 set beats clear", r, 32'h1);
    wr(A_PEND, 32'h1); rd(A_PEND, r); chk("R8 later clear", r, 32'h0);

    // R3 R4 R10 sweep of start, restart and wait
    for (int l = 0; l <= 5; l++) begin
      for (int p = 0; p <= 4; p++) begin
        for (int d = 0; d <= 11; d++) begin
          string tag;
          wr(A_RUN, 32'h0);
          wr(A_START, 32'(l));
          wr(A_RESTART, 32'(p));
          idle(1);
          wr(A_PEND, 32'h1);
          wr(A_RUN, 32'h1);
          idle(d);
          wr(A_SNAP, 32'hFFFF_FFFF);
          if (d < l)       tag = "R3 countdown";
          else if (p == 0) tag = "R4 single interval";
          else             tag = "R10 periodic";
          rd(A_VALUE, r);
          chk(tag, r, 32'(exp_count(l, p, d)));
          rd(A_STAT, r);
          chk("R6 status level", r, {31'h0, exp_count(l, p, d + 1) != 0});
          rd(A_PEND, r);
          chk("R7 pending", r, {31'h0, exp_pend(l, p, d + 1)});
          chk("R9 irq", {31'h0, irq}, {31'h0, exp_pend(l, p, d + 1)});
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule